// File: doc/BRIEF.md
# Sync-Code Slot Timing Detector

This block recovers slot timing from a stream of real pass-band samples taken at four times the chip rate. A primary sync code whose chips are all +1 or -1 is correlated against the stream. Because every code chip is ±1, each tap is added or subtracted and no multiplier is used. Taps are spaced one chip (four samples) apart. A correlation value comes out once per chip, after the fourth sample of that chip.

Each correlation value is squared into an energy. That energy is folded into a per-chip-position average over several slots. The average uses an exponential forgetting factor of 2^-k. When the programmed number of slots has been accumulated, the averaging memory is scanned. The chip position holding the largest average is reported as the slot timing estimate.

Software starts a run with a pulse, after setting the forgetting shift, the number of slots and the code. It then feeds samples with a valid strobe and waits for the done flag.

Top module: `slot_timing_detector`

## Requirements
- R1: After reset, busy_o and done_o are 0, and timing_o and peak_o are 0.
- R2: For the chip that ends at accepted sample n of a run, the correlation is C = sum over i of s_i * x[n - 4*(CODE_LEN-1-i)]. Here s_i is +1 when code bit i is 1 and -1 when it is 0, so bit 0 is the oldest tap. Samples before the first accepted sample of the run count as zero. One value is formed for every four accepted samples, at the fourth sample of each chip.
- R3: The energy of a chip is C squared.
- R4: Chip j of a slot maps to average entry j, where j is the run's chip count modulo SLOT_CHIPS. In the first slot of a run, the entry is loaded with the energy E. In later slots it becomes A + floor((E - A) / 2^k). The shift k is taken from shift_i at start, and a value of 0 is used as 1.
- R5: A run accumulates num_slots_i whole slots, which is num_slots_i*SLOT_CHIPS*4 accepted samples. A value of 0 means one slot.
- R6: After accumulation the block scans all entries. It then raises done_o with busy_o low, timing_o set to the lowest index holding the largest average, and peak_o set to that average. When all entries are equal, the index is 0.
- R7: A sample is taken only when sample_valid_i is high during accumulation. Invalid cycles do not advance the chip phase. Samples offered after the last one of the run, during the scan, or while idle or done have no effect.
- R8: shift_i, num_slots_i and code_i are captured on an accepted start, and later changes to them do not affect the run. A start_i pulse while busy_o is high is ignored.
- R9: A start accepted while idle or done clears done_o, raises busy_o on the next cycle and clears the sample history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new run |
| shift_i | input | SHIFT_W | Forgetting shift k (factor 2^-k) |
| num_slots_i | input | SLOT_CNT_W | Slots to accumulate, 0 means 1 |
| code_i | input | CODE_LEN | Sync code, 1 = +1 and 0 = -1, bit 0 is the oldest tap |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMP_W | Signed sample at four times the chip rate |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Result valid |
| timing_o | output | CHIP_W | Chip index of the peak |
| peak_o | output | ENG_W | Averaged energy at the peak |

## Verification
The bench builds the block with 8-bit samples, an 8-chip code and 16-chip slots. With these values, whole multi-slot runs take only a few hundred samples, so one case can cover exponential averaging over up to six slots, a zero slot count, a zero shift and strobe gaps. The short slot makes ties between two equal code bursts easy to construct. It also makes a run with all-zero samples easy, and both check the lowest-index rule. A start pulse and changed settings in the middle of a run, plus junk samples fed during the scan, show that captured settings and the end of accumulation hold.

// File: rtl/stt_pkg.sv
package stt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_SCAN,
    ST_DONE
  } stt_state_e;
endpackage

// File: rtl/stt_correlator.sv
module stt_correlator #(
  parameter int SAMP_W   = 12,
  parameter int CODE_LEN = 256,
  parameter int OSR      = 4,
  parameter int CORR_W   = 21,
  localparam int HIST_LEN = (CODE_LEN - 1) * OSR + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     shift_en_i,
  input  logic signed [SAMP_W-1:0] sample_i,
  input  logic [CODE_LEN-1:0]      code_i,
  output logic signed [CORR_W-1:0] corr_o
);

  logic signed [SAMP_W-1:0] hist_q [HIST_LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HIST_LEN; i++) hist_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < HIST_LEN; i++) hist_q[i] <= '0;
    end else if (shift_en_i) begin
      hist_q[0] <= sample_i;
      for (int i = 1; i < HIST_LEN; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // code bit i pairs with the tap (CODE_LEN-1-i) chips back
  always_comb begin
    logic signed [CORR_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < CODE_LEN; i++) begin
      if (code_i[i]) acc = acc + CORR_W'(hist_q[(CODE_LEN-1-i)*OSR]);
      else           acc = acc - CORR_W'(hist_q[(CODE_LEN-1-i)*OSR]);
    end
    corr_o = acc;
  end

endmodule

// File: rtl/stt_avg_mem.sv
module stt_avg_mem #(
  parameter int ENG_W   = 42,
  parameter int DEPTH   = 2560,
  parameter int ADDR_W  = 12,
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ENG_W-1:0]   energy_i,
  input  logic               load_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [ENG_W-1:0]   rd_data_o
);

  logic [ENG_W-1:0]  mem_q [DEPTH];
  logic [ENG_W-1:0]  old_val;
  logic signed [ENG_W:0] diff, step;
  logic [ENG_W-1:0]  nxt_val;

  assign old_val = mem_q[addr_i];
  assign diff    = $signed({1'b0, energy_i}) - $signed({1'b0, old_val});
  assign step    = diff >>> shift_i;
  assign nxt_val = ENG_W'($signed({1'b0, old_val}) + step);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= load_i ? energy_i : nxt_val;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R4: a blended update lands between the old average and the new energy
  a_r4_avg_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !load_i) |=>
      (($past(energy_i) >= $past(old_val))
        ? (mem_q[$past(addr_i)] >= $past(old_val) && mem_q[$past(addr_i)] <= $past(energy_i))
        : (mem_q[$past(addr_i)] <= $past(old_val) && mem_q[$past(addr_i)] >= $past(energy_i))));

endmodule

// File: rtl/stt_peak_scan.sv
module stt_peak_scan #(
  parameter int ENG_W  = 42,
  parameter int DEPTH  = 2560,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ENG_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              fin_o,
  output logic [ADDR_W-1:0] best_idx_o,
  output logic [ENG_W-1:0]  best_val_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              active_q, fin_q;
  logic [ADDR_W-1:0] addr_q, best_idx_q;
  logic [ENG_W-1:0]  best_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      fin_q      <= 1'b0;
      addr_q     <= '0;
      best_idx_q <= '0;
      best_val_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        active_q   <= 1'b1;
        addr_q     <= '0;
        best_idx_q <= '0;
        best_val_q <= '0;
      end else if (active_q) begin
        // strict compare keeps the lowest index on ties
        if (rd_data_i > best_val_q) begin
          best_val_q <= rd_data_i;
          best_idx_q <= addr_q;
        end
        if (addr_q == LAST) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign rd_addr_o  = addr_q;
  assign fin_o      = fin_q;
  assign best_idx_o = best_idx_q;
  assign best_val_o = best_val_q;

  // R6: running maximum never drops during a scan
  a_r6_best_nondec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !go_i) |=> (best_val_q >= $past(best_val_q)));

endmodule

// File: rtl/slot_timing_detector.sv
module slot_timing_detector import stt_pkg::*; #(
  parameter int SAMP_W     = 12,
  parameter int CODE_LEN   = 256,
  parameter int OSR        = 4,
  parameter int SLOT_CHIPS = 2560,
  parameter int SLOT_CNT_W = 8,
  parameter int SHIFT_W    = 3,
  localparam int CORR_W = SAMP_W + $clog2(CODE_LEN) + 1,
  localparam int ENG_W  = 2 * CORR_W,
  localparam int CHIP_W = $clog2(SLOT_CHIPS),
  localparam int PH_W   = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  input  logic [SLOT_CNT_W-1:0]    num_slots_i,
  input  logic [CODE_LEN-1:0]      code_i,
  input  logic                     sample_valid_i,
  input  logic signed [SAMP_W-1:0] sample_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [CHIP_W-1:0]        timing_o,
  output logic [ENG_W-1:0]         peak_o
);

  stt_state_e state_q;

  logic [SHIFT_W-1:0]    shift_q;
  logic [SLOT_CNT_W-1:0] nslots_q, slot_q;
  logic [CODE_LEN-1:0]   code_q;
  logic [PH_W-1:0]       phase_q;
  logic [CHIP_W-1:0]     chip_q;
  logic                  rdy_q, rdy_first_q;
  logic [CHIP_W-1:0]     rdy_chip_q;

  logic                     accept, start_ok, last_phase, last_chip, last_slot;
  logic signed [CORR_W-1:0] corr;
  logic [CORR_W-1:0]        mag;
  logic [ENG_W-1:0]         energy;
  logic                     scan_go, scan_fin;
  logic [CHIP_W-1:0]        scan_addr;
  logic [ENG_W-1:0]         scan_data;

  assign start_ok   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign accept     = (state_q == ST_RUN) && sample_valid_i;
  assign last_phase = (phase_q == PH_W'(OSR - 1));
  assign last_chip  = (chip_q == CHIP_W'(SLOT_CHIPS - 1));
  assign last_slot  = (slot_q == nslots_q - 1'b1);
  assign scan_go    = (state_q == ST_DRAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      shift_q     <= SHIFT_W'(1);
      nslots_q    <= SLOT_CNT_W'(1);
      code_q      <= '0;
      phase_q     <= '0;
      chip_q      <= '0;
      slot_q      <= '0;
      rdy_q       <= 1'b0;
      rdy_first_q <= 1'b0;
      rdy_chip_q  <= '0;
    end else begin
      rdy_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            shift_q  <= (shift_i == '0) ? SHIFT_W'(1) : shift_i;
            nslots_q <= (num_slots_i == '0) ? SLOT_CNT_W'(1) : num_slots_i;
            code_q   <= code_i;
            phase_q  <= '0;
            chip_q   <= '0;
            slot_q   <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (accept) begin
            phase_q <= last_phase ? '0 : phase_q + 1'b1;
            if (last_phase) begin
              rdy_q       <= 1'b1;
              rdy_chip_q  <= chip_q;
              rdy_first_q <= (slot_q == '0);
              chip_q      <= last_chip ? '0 : chip_q + 1'b1;
              if (last_chip) begin
                slot_q <= slot_q + 1'b1;
                if (last_slot) state_q <= ST_DRAIN;
              end
            end
          end
        end
        ST_DRAIN: state_q <= ST_SCAN;
        ST_SCAN:  if (scan_fin) state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  stt_correlator #(
    .SAMP_W  (SAMP_W),
    .CODE_LEN(CODE_LEN),
    .OSR     (OSR),
    .CORR_W  (CORR_W)
  ) u_corr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .shift_en_i(accept),
    .sample_i  (sample_i),
    .code_i    (code_q),
    .corr_o    (corr)
  );

  assign mag    = corr[CORR_W-1] ? CORR_W'(-corr) : CORR_W'(corr);
  assign energy = ENG_W'(mag) * ENG_W'(mag);

  stt_avg_mem #(
    .ENG_W  (ENG_W),
    .DEPTH  (SLOT_CHIPS),
    .ADDR_W (CHIP_W),
    .SHIFT_W(SHIFT_W)
  ) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (rdy_q),
    .addr_i   (rdy_chip_q),
    .energy_i (energy),
    .load_i   (rdy_first_q),
    .shift_i  (shift_q),
    .rd_addr_i(scan_addr),
    .rd_data_o(scan_data)
  );

  stt_peak_scan #(
    .ENG_W (ENG_W),
    .DEPTH (SLOT_CHIPS),
    .ADDR_W(CHIP_W)
  ) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (scan_go),
    .rd_data_i (scan_data),
    .rd_addr_o (scan_addr),
    .fin_o     (scan_fin),
    .best_idx_o(timing_o),
    .best_val_o(peak_o)
  );

  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o = (state_q == ST_DONE);

  // R2: one correlation per chip, never on consecutive cycles
  if (OSR > 1) begin : g_rate_chk
    a_r2_chip_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdy_q |=> !rdy_q);
  end

  // R7: averages change only from samples taken during accumulation
  a_r7_update_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |-> ($past(state_q) == ST_RUN));

  // R8: captured settings hold while a run is active
  a_r8_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(shift_q) && $stable(nslots_q) && $stable(code_q)));

endmodule

// File: tb/slot_timing_detector_test.sv
`timescale 1ns/1ps
module slot_timing_detector_test;

  localparam int SW = 8, CL = 8, SC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0;
  logic [2:0] shift = '0;
  logic [3:0] nslots = '0;
  logic [7:0] code = '0;
  logic signed [7:0] sample = '0;
  logic busy, done;
  logic [3:0] timing;
  logic [23:0] peak;

  int checks = 0, failures = 0;
  int samp [512];
  int lfsr = 16'hACE1;

  always #5 clk = ~clk;

  slot_timing_detector #(
    .SAMP_W(SW), .CODE_LEN(CL), .OSR(4), .SLOT_CHIPS(SC), .SLOT_CNT_W(4), .SHIFT_W(3)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shift_i(shift),
    .num_slots_i(nslots), .code_i(code), .sample_valid_i(valid), .sample_i(sample),
    .busy_o(busy), .done_o(done), .timing_o(timing), .peak_o(peak)
  );

  typedef struct packed {
    logic [7:0] code;
    logic [2:0] k;
    logic [3:0] slots;
    logic [3:0] pos;
    logic [7:0] amp;
    logic       noise;
    logic [1:0] gap;
    logic [3:0] exp_t;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'hB4, 3'd1, 4'd3, 4'd0, 8'd30, 1'b1, 2'd0, 4'd7},   // R2 R4 R5 R6
    '{8'h2D, 3'd3, 4'd4, 4'd5, 8'd25, 1'b1, 2'd1, 4'd12},  // R4 R7 gaps
    '{8'hF0, 3'd7, 4'd2, 4'd8, 8'd30, 1'b0, 2'd2, 4'd15},  // R4 slow factor
    '{8'h96, 3'd0, 4'd0, 4'd3, 8'd30, 1'b1, 2'd0, 4'd10},  // R4 k=0, R5 slots=0
    '{8'h5A, 3'd2, 4'd6, 4'd1, 8'd20, 1'b1, 2'd3, 4'd8}    // R5 six slots
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int noise_val();
    lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
    return (lfsr % 3) - 1;
  endfunction

  task automatic build(input logic [7:0] c, input int pos, input int amp, input bit nz,
                       input bit dual, input int total);
    for (int n = 0; n < total; n++) begin
      int q, v;
      q = (n / 4) % SC;
      v = nz ? noise_val() : 0;
      if (q - pos >= 0 && q - pos < CL) v += c[q-pos] ? amp : -amp;
      if (dual && q - pos - 8 >= 0 && q - pos - 8 < CL) v += c[q-pos-8] ? amp : -amp;
      samp[n] = v;
    end
  endtask

  // independent reference of R2..R6
  task automatic model(input logic [7:0] c, input int k, input int ns,
                       output int et, output longint ep);
    longint a [SC];
    for (int m = 0; m < ns * SC; m++) begin
      longint cr, e;
      cr = 0;
      for (int i = 0; i < CL; i++) begin
        int idx, x;
        idx = 4 * m + 3 - 4 * (CL - 1 - i);
        x = (idx >= 0) ? samp[idx] : 0;
        cr += c[i] ? x : -x;
      end
      e = cr * cr;
      if (m < SC) a[m % SC] = e;
      else a[m % SC] = a[m % SC] + ((e - a[m % SC]) >>> k);
    end
    et = 0; ep = 0;
    for (int j = 0; j < SC; j++) if (a[j] > ep) begin ep = a[j]; et = j; end
  endtask

  task automatic run_case(input logic [7:0] c, input int k, input int ns, input int pos,
                          input int amp, input bit nz, input int gap, input bit dual,
                          input bit midstart, input int exp_t, input bit use_exp,
                          input string tag);
    int ke, ne, total, et, wd;
    longint ep;
    ke = (k == 0) ? 1 : k;
    ne = (ns == 0) ? 1 : ns;
    total = ne * SC * 4;
    build(c, pos, amp, nz, dual, total);
    model(c, ke, ne, et, ep);
    @(negedge clk);
    start = 1'b1; shift = 3'(k); nslots = 4'(ns); code = c;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, {tag, " R9 start"}, {busy, done}, 2);
    for (int n = 0; n < total; n++) begin
      @(negedge clk);
      valid = 1'b1; sample = 8'(samp[n]);
      if (midstart && n == total / 2) begin
        start = 1'b1; shift = 3'd6; nslots = 4'd1; code = ~c;  // R8
      end else start = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        valid = 1'b0; start = 1'b0; sample = 8'sd99;  // R7 strobe low
      end
    end
    wd = 0;
    @(negedge clk);
    start = 1'b0; valid = 1'b1; sample = 8'sd127;   // R7 samples after the run
    while (!done && wd < 2000) begin
      @(negedge clk);
      wd++;
    end
    valid = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, {tag, " R6 done"}, {busy, done}, 1);
    chk(timing == 4'(et), {tag, " R6 timing vs model"}, timing, et);
    chk(peak == 24'(ep), {tag, " R4 peak vs model"}, peak, ep);
    if (use_exp) chk(timing == 4'(exp_t), {tag, " R2 planted timing"}, timing, exp_t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog R6 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
    chk(timing == 0 && peak == 0, "R1 result", peak, 0);
    rst_n = 1'b1;
    @(negedge clk);
    valid = 1'b1; sample = 8'sd50;   // R7 idle samples
    repeat (4) @(negedge clk);
    valid = 1'b0;
    chk(busy == 0 && done == 0, "R7 idle ignored", {busy, done}, 0);

    for (int v = 0; v < NV; v++)
      run_case(VECS[v].code, VECS[v].k, VECS[v].slots, VECS[v].pos, VECS[v].amp,
               VECS[v].noise, VECS[v].gap, 1'b0, 1'b0, VECS[v].exp_t, 1'b1, "vec");

    // R6 all-zero input: lowest index wins
    run_case(8'hB4, 1, 2, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b1, "zero");
    chk(peak == 0, "R3 zero energy", peak, 0);
    // R6 two equal bursts: first index wins
    run_case(8'hB4, 1, 2, 0, 30, 1'b0, 0, 1'b1, 1'b0, 7, 1'b1, "tie");
    // R8 start and new settings mid-run ignored
    run_case(8'h2D, 2, 3, 4, 25, 1'b1, 0, 1'b0, 1'b1, 11, 1'b1, "midstart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule